// File: doc/BRIEF.md
# Dual-Word Parallel Synthesiser Programming Interface

This block is the control front end of a frequency synthesiser. A host writes programming words over a 16-bit parallel bus, together with an address bit and a strobe. The address bit picks one of two holding buffers. One holds the RF divider word: A count, M count and charge-pump gain. The other holds the reference divider word: reference count, phase-detector state and sense. The strobe is level sensitive. While it is high, the selected buffer follows the bus. When it falls, both buffers are copied into the live control registers that feed the dividers and the phase detector.

Strobe, address and bus are brought into the system clock domain through a two-stage synchroniser. The falling edge of the strobe is detected on the synchronised copy. While the synchronised strobe is high, the block holds the divider counters in reset and turns the charge pump off. When a new set of values takes effect, the block raises a one-cycle update pulse.

The reference word usually changes rarely. Once it is set, a change of frequency takes one RF word load. The reference buffer keeps its contents across such loads.

Top module: `synth_prog_if`

## Requirements
- R1: While `rst_n` is low at a clock edge, all live fields read all-ones. Specifically, `a_count`=7, `m_count`=2047, `cp_gain`=3, `ref_count`=1023, `pd_state`=3 and `pd_sense`=1. In the same condition, `div_reset` is 1, `cp_enable` is 0 and `update` is 0. One edge after reset is released, with strobe low, `div_reset` is 0 and `cp_enable` is 1.
- R2: A word loaded with `addr`=1 updates the RF fields. `a_count` takes bus bits 2:0, `m_count` takes bits 13:3 and `cp_gain` takes bits 15:14. The reference fields keep their values.
- R3: A word loaded with `addr`=0 updates the reference fields. `ref_count` takes bus bits 9:0, `pd_state` takes bits 11:10 and `pd_sense` takes bit 12. Bits 15:13 have no effect on any output. The RF fields keep their values.
- R4: Loading is level triggered. The stored word is the bus value present at the last clock edge at which the strobe was sampled high. Earlier values seen during the same strobe pulse are discarded.
- R5: From the third clock edge after the strobe rises, `div_reset` is 1 and `cp_enable` is 0. They stay that way until the third edge after the strobe falls.
- R6: At the third clock edge after the strobe falls, the live fields take the buffered words. `div_reset` drops and `cp_enable` rises at that edge, and `update` is 1 for exactly that one cycle. Before that edge, the live fields still hold their old values.
- R7: After several RF-only loads, the reference fields still hold the last reference word that was loaded.
- R8: While the strobe is low, changes on `data` and `addr` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data | input | 16 | Programming word bus (asynchronous) |
| addr | input | 1 | Buffer select: 1 selects the RF word, 0 selects the reference word (asynchronous) |
| strobe | input | 1 | Level-sensitive load strobe (asynchronous) |
| a_count | output | 3 | Live A count |
| m_count | output | 11 | Live M count |
| cp_gain | output | 2 | Live charge-pump gain code |
| ref_count | output | 10 | Live reference divide count |
| pd_state | output | 2 | Live phase-detector state code |
| pd_sense | output | 1 | Live phase-detector sense |
| div_reset | output | 1 | Holds the divider counters in reset |
| cp_enable | output | 1 | Charge pump enable |
| update | output | 1 | One-cycle pulse when new values take effect |

## Verification
Every result in this block arrives a fixed number of clock edges after the stimulus that causes it. Inputs pass through two synchroniser flops, and one more register sits before the outputs. So `div_reset` rises, and the live fields, `update` and `cp_enable` change, exactly three edges after the strobe rises or falls. The bench drives its inputs on falling clock edges and counts rising edges from the strobe change. It samples on the falling edge after the second rising edge to confirm nothing has moved early. It then samples again after the third rising edge for the new value, and once more one cycle later to confirm `update` has dropped. Checks that the bus is ignored while the strobe is low sample after more than three edges, so any leak through the synchroniser would already be visible.

// File: rtl/synth_prog_pkg.sv
// Package: field layout of the two programming words.
// Assumes a 16-bit bus; positions are fixed by the divider/detector decoders.
package synth_prog_pkg;
    localparam int BUS_W   = 16;
    localparam int A_W     = 3;
    localparam int M_W     = 11;
    localparam int GAIN_W  = 2;
    localparam int REF_W   = 10;
    localparam int PDS_W   = 2;
    localparam int REFU_W  = REF_W + PDS_W + 1;   // used bits of reference word

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [M_W-1:0]    m;
        logic [A_W-1:0]    a;
    } rf_word_t;

    typedef struct packed {
        logic              sense;
        logic [PDS_W-1:0]  state;
        logic [REF_W-1:0]  rcount;
    } ref_word_t;
endpackage

// File: rtl/sp_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes bits of the bundle are quasi-static relative to each other
// around strobe edges (bus held stable by the host while it settles).
module sp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the bundle one stage towards the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_word_buffer.sv
// Module: one holding buffer, transparent to the bus while the synchronised
// strobe is high and this buffer is addressed; frozen otherwise.
// Assumes inputs are already in the clk domain.
module sp_word_buffer #(
    parameter int   W   = 16,
    parameter logic SEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Purpose: follow the bus while open, hold all-ones from reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      q <= '1;
        else if (capture && sel == SEL)  q <= din;
    end

    // R8: a closed buffer never changes
    assert_buf_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(q));
endmodule

// File: rtl/sp_live_regs.sv
// Module: live control registers, strobe-fall detection and the
// divider-reset / update outputs.
// Assumes stb is the synchronised strobe.
module sp_live_regs
    import synth_prog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb,
    input  rf_word_t  rf_buf,
    input  ref_word_t ref_buf,
    output rf_word_t  rf_live,
    output ref_word_t ref_live,
    output logic      div_hold,
    output logic      upd
);
    logic stb_d;
    logic fall;

    assign fall = stb_d && !stb;

    // Purpose: remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_d <= 1'b0;
        else        stb_d <= stb;
    end

    // Purpose: transfer both buffers into the live registers on strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_live  <= '1;
            ref_live <= '1;
        end else if (fall) begin
            rf_live  <= rf_buf;
            ref_live <= ref_buf;
        end
    end

    // Purpose: hold dividers in reset while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) div_hold <= 1'b1;
        else        div_hold <= stb;
    end

    // Purpose: one-cycle pulse marking the load.
    always_ff @(posedge clk) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= fall;
    end

    // R6: update lasts a single cycle
    assert_upd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);
    // R6: live values only move together with the update pulse
    assert_live_with_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(rf_live) && $stable(ref_live)) |-> upd);
    // R6: at update the dividers are released
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> !div_hold);
    // R5: a load is always preceded by a held-reset cycle
    assert_held_before_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(div_hold));
endmodule

// File: rtl/synth_prog_if.sv
// Module: top of the parallel programming interface. Synchronises the
// bus, address and strobe, routes words to the RF or reference buffer,
// and presents decoded live fields plus reset/enable/update controls.
// Assumes the host keeps data and addr stable near strobe edges.
module synth_prog_if
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  data,
    input  logic              addr,
    input  logic              strobe,
    output logic [A_W-1:0]    a_count,
    output logic [M_W-1:0]    m_count,
    output logic [GAIN_W-1:0] cp_gain,
    output logic [REF_W-1:0]  ref_count,
    output logic [PDS_W-1:0]  pd_state,
    output logic              pd_sense,
    output logic              div_reset,
    output logic              cp_enable,
    output logic              update
);
    localparam int BUNDLE_W = BUS_W + 2;

    logic [BUNDLE_W-1:0] bundle_s;
    logic [BUS_W-1:0]    data_s;
    logic                addr_s;
    logic                stb_s;
    logic [BUS_W-1:0]    rf_q;
    logic [REFU_W-1:0]   ref_q;
    rf_word_t            rf_live;
    ref_word_t           ref_live;
    logic                hold;

    sp_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({strobe, addr, data}), .q(bundle_s)
    );

    assign {stb_s, addr_s, data_s} = bundle_s;

    sp_word_buffer #(.W(BUS_W), .SEL(1'b1)) u_rf_buf (
        .clk(clk), .rst_n(rst_n), .capture(stb_s), .sel(addr_s),
        .din(data_s), .q(rf_q)
    );

    sp_word_buffer #(.W(REFU_W), .SEL(1'b0)) u_ref_buf (
        .clk(clk), .rst_n(rst_n), .capture(stb_s), .sel(addr_s),
        .din(data_s[REFU_W-1:0]), .q(ref_q)
    );

    sp_live_regs u_live (
        .clk(clk), .rst_n(rst_n), .stb(stb_s),
        .rf_buf(rf_word_t'(rf_q)), .ref_buf(ref_word_t'(ref_q)),
        .rf_live(rf_live), .ref_live(ref_live),
        .div_hold(hold), .upd(update)
    );

    assign a_count   = rf_live.a;
    assign m_count   = rf_live.m;
    assign cp_gain   = rf_live.gain;
    assign ref_count = ref_live.rcount;
    assign pd_state  = ref_live.state;
    assign pd_sense  = ref_live.sense;
    assign div_reset = hold;
    assign cp_enable = !hold;
endmodule

// File: tb/tb_synth_prog_if.sv
`timescale 1ns/1ps
module tb_synth_prog_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data = 16'hFFFF;
    logic        addr = 1'b1;
    logic        strobe = 1'b0;
    logic [2:0]  a_count;
    logic [10:0] m_count;
    logic [1:0]  cp_gain;
    logic [9:0]  ref_count;
    logic [1:0]  pd_state;
    logic        pd_sense;
    logic        div_reset, cp_enable, update;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] rf_exp  = 16'hFFFF;
    logic [12:0] ref_exp = 13'h1FFF;

    always #2.5 clk = ~clk;

    synth_prog_if dut (
        .clk(clk), .rst_n(rst_n), .data(data), .addr(addr), .strobe(strobe),
        .a_count(a_count), .m_count(m_count), .cp_gain(cp_gain),
        .ref_count(ref_count), .pd_state(pd_state), .pd_sense(pd_sense),
        .div_reset(div_reset), .cp_enable(cp_enable), .update(update)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rf_out();
        return {cp_gain, m_count, a_count};
    endfunction

    function automatic logic [12:0] ref_out();
        return {pd_sense, pd_state, ref_count};
    endfunction

    task automatic check_fields(input string req);
        chk(rf_out() == rf_exp, req, "rf fields", {16'h0, rf_out()}, {16'h0, rf_exp});
        chk(ref_out() == ref_exp, req, "ref fields", {19'h0, ref_out()}, {19'h0, ref_exp});
    endtask

    // Load one word; mid is an earlier value shown while strobe is high (R4).
    task automatic load(input logic a, input logic [15:0] w,
                        input bit use_mid, input logic [15:0] mid);
        @(negedge clk);
        addr = a; data = use_mid ? mid : w; strobe = 1'b1;
        repeat (2) @(negedge clk);
        chk(div_reset == 1'b0, "R5", "div_reset before 3rd edge", div_reset, 0);
        @(negedge clk);
        chk(div_reset == 1'b1 && cp_enable == 1'b0, "R5", "hold after rise",
            {div_reset, cp_enable}, 2'b10);
        data = w;
        repeat (3) @(negedge clk);
        strobe = 1'b0;
        repeat (2) @(negedge clk);
        chk(update == 1'b0 && div_reset == 1'b1, "R6", "not yet loaded",
            {update, div_reset}, 2'b01);
        check_fields("R6");
        if (a) rf_exp = w; else ref_exp = w[12:0];
        @(negedge clk);
        chk(update == 1'b1 && div_reset == 1'b0 && cp_enable == 1'b1, "R6",
            "release", {update, div_reset, cp_enable}, 3'b101);
        check_fields(a ? "R2" : "R3");
        if (use_mid) check_fields("R4");
        @(negedge clk);
        chk(update == 1'b0, "R6", "update single cycle", update, 0);
    endtask

    initial begin
        logic [15:0] ref_saved;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(div_reset == 1'b1 && cp_enable == 1'b0 && update == 1'b0, "R1",
            "controls in reset", {div_reset, cp_enable, update}, 3'b100);
        check_fields("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(div_reset == 1'b0 && cp_enable == 1'b1, "R1", "after reset",
            {div_reset, cp_enable}, 2'b01);

        // Directed corners
        load(1'b1, 16'h0000, 0, 0);
        load(1'b0, 16'hE000, 0, 0);               // R3: spare bits only set
        load(1'b1, 16'h5A5A, 1, 16'hFFFF);        // R4
        load(1'b0, 16'h1ABC, 1, 16'h0001);        // R4 on reference buffer

        // R7: several RF-only loads keep the reference word
        ref_saved = {3'b0, ref_exp};
        for (int i = 0; i < 4; i++) begin
            load(1'b1, 16'($urandom), 0, 0);
            chk(ref_out() == ref_saved[12:0], "R7", "ref retained",
                {19'h0, ref_out()}, {16'h0, ref_saved});
        end

        // R8: bus and address activity with strobe low
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            data = 16'($urandom); addr = 1'($urandom);
        end
        repeat (5) @(negedge clk);
        check_fields("R8");
        chk(update == 1'b0 && div_reset == 1'b0, "R8", "controls idle",
            {update, div_reset}, 2'b00);

        // Random mix
        for (int i = 0; i < 30; i++) begin
            logic [15:0] w;
            logic [15:0] m;
            w = 16'($urandom);
            m = 16'($urandom);
            load(1'($urandom), w, 1'($urandom), m);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule